// File: doc/BRIEF.md
# USB Line-State Force and Suspend Controller

This block sits between a packet serializer and a USB transceiver front end. A CPU programs it over an 8-bit bus that uses one address line to tell an index write from a data write. A two-bit field in the control register can take over the D+/D- pair and hold it at SE0 (bus reset), J or K. Software uses this to reset a newly attached device: it writes 08h, waits for the reset time, then writes 00h. A second register holds a polarity-swap bit that exchanges the D+ and D- outputs, which is needed when a low-speed device is attached directly.

The control register also carries a speed-select bit, an SOF-enable bit and a suspend bit. While suspended, the block drops its clock-enable and transceiver-enable outputs, puts the RAM into sleep and floats the bus drive. It leaves suspend in one of two ways. The first is bus activity, meaning the synchronized receive pair moves away from the idle state of the selected speed. The second is a bare CPU data write, which is a data-phase write that no index write came before.

There are three state machines. The CPU port machine has the states PORT_ADDR_WAIT and PORT_ADDR_HELD. An index write moves it to PORT_ADDR_HELD. A data write returns it to PORT_ADDR_WAIT. The power machine has the states PWR_RUN and PWR_SUSPEND. It enters PWR_SUSPEND on a control write with bit 6 set. It returns to PWR_RUN on a control write with bit 6 clear, on a bare write, or on bus activity. The line machine has the states LINK_PASS, LINK_SE0, LINK_J and LINK_K. On each bit-clock enable it loads the state named by the force field.

Top module: `usb_line_ctrl`

## Requirements
- R1: After reset the control register (index 5) and the polarity register (index 15) both read 00h. clk_en and xcvr_en are 1, ram_sleep, low_speed and sof_en are 0, and the USB pair and its output enable follow the serializer inputs.
- R2: A write with cpu_a0=0 latches cpu_wdata as the register index, and cpu_rdata shows the indexed register from then on. The next write with cpu_a0=1 updates that register. In the control register, bits 7, 2 and 1 always read 0. Only bit 6 of the polarity register is stored. Writes to any other index are dropped, and such indices read 00h.
- R3: The force field is control bits 4:3. With polarity swap off, 00 passes the serializer's dp, dm and oe through, 01 drives dp=0 dm=0, 10 drives dp=1 dm=0, and 11 drives dp=0 dm=1. Every forced code holds usb_oe at 1.
- R4: A new force value reaches the line on the first clock edge where bit_ce is 1. While bit_ce is 0, the line output keeps its previous state.
- R5: When bit 6 of the polarity register is 1, usb_dp and usb_dm are exchanged in every force mode, pass-through included.
- R6: Writing control bit 6 = 1 enters suspend. From the edge of that write, clk_en=0, xcvr_en=0, ram_sleep=1 and usb_oe=0, and control bit 6 reads 1.
- R7: While suspended, a receive pair that moves from idle to any other state clears suspend on the third clock edge after the change. Idle is dp=1 dm=0 when bit 5 is 0 and dp=0 dm=1 when bit 5 is 1. A pair that stays idle leaves suspend in place.
- R8: A data write (cpu_a0=1) that has no index write before it since the last data write clears suspend on its edge and changes no register. When the block is not suspended, such a write has no visible effect.
- R9: Control bit 5 drives low_speed, and control bit 0 drives sof_en.
- R10: Writing 08h to the control register holds the bus at SE0 with the output enabled. Writing 00h afterwards returns the bus to serializer pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per access |
| cpu_a0 | input | 1 | 0 = index write, 1 = data write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Contents of the currently indexed register |
| bit_ce | input | 1 | Bit-clock enable for the line state |
| ser_dp | input | 1 | Serializer D+ drive |
| ser_dm | input | 1 | Serializer D- drive |
| ser_oe | input | 1 | Serializer output enable |
| rx_dp | input | 1 | Received D+ (asynchronous) |
| rx_dm | input | 1 | Received D- (asynchronous) |
| usb_dp | output | 1 | D+ to transceiver |
| usb_dm | output | 1 | D- to transceiver |
| usb_oe | output | 1 | Transceiver output enable |
| low_speed | output | 1 | Speed select, 1 = low speed |
| sof_en | output | 1 | SOF output enable |
| clk_en | output | 1 | Internal clock enable, 0 in suspend |
| xcvr_en | output | 1 | Transmit transceiver enable, 0 in suspend |
| ram_sleep | output | 1 | RAM suspend request |

## Verification
Three timings matter. Register contents, suspend entry and bare-write wake are due on the clock edge that samples the write. A force value reaches the pins one bit_ce edge after that, and a receive-pair change clears suspend on the third edge after it is applied. The bench drives every input at a falling edge and counts the rising edges before it samples, so each check falls between edges. For R7 the bench checks that suspend still holds after two edges and is gone after the third. The line sweep covers all 64 combinations of polarity, force code and serializer pattern, and computes the expected pair arithmetically.

// File: rtl/usb_line_pkg.sv
package usb_line_pkg;

    localparam int CTRL_SUSP_BIT  = 6;
    localparam int CTRL_SPEED_BIT = 5;
    localparam int CTRL_FORCE_LO  = 3;
    localparam int CTRL_SOF_BIT   = 0;
    localparam int POL_SWAP_BIT   = 6;

    typedef enum logic [1:0] {
        LINK_PASS = 2'b00,
        LINK_SE0  = 2'b01,
        LINK_J    = 2'b10,
        LINK_K    = 2'b11
    } link_state_e;

    typedef enum logic {
        PWR_RUN     = 1'b0,
        PWR_SUSPEND = 1'b1
    } pwr_state_e;

    typedef enum logic {
        PORT_ADDR_WAIT = 1'b0,
        PORT_ADDR_HELD = 1'b1
    } port_state_e;

    typedef struct packed {
        logic dp;
        logic dm;
    } line_pair_t;

endpackage

// File: rtl/usb_cpu_port.sv
module usb_cpu_port
    import usb_line_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic              cpu_a0,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] idx_q,
    output logic              reg_wr,
    output logic              bare_wr,
    output logic              addr_held
);

    port_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PORT_ADDR_WAIT;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cpu_we && !cpu_a0)
                idx_q <= cpu_wdata;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_ADDR_WAIT: if (cpu_we && !cpu_a0) state_d = PORT_ADDR_HELD;
            PORT_ADDR_HELD: if (cpu_we && cpu_a0)  state_d = PORT_ADDR_WAIT;
            default:        state_d = PORT_ADDR_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        reg_wr    = 1'b0;
        bare_wr   = 1'b0;
        addr_held = 1'b0;
        unique case (state_q)
            PORT_ADDR_WAIT: bare_wr = cpu_we && cpu_a0;
            PORT_ADDR_HELD: begin
                reg_wr    = cpu_we && cpu_a0;
                addr_held = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/usb_pwr_fsm.sv
module usb_pwr_fsm
    import usb_line_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_dp,
    input  logic rx_dm,
    input  logic low_speed,
    input  logic set_wr,
    input  logic set_val,
    input  logic bare_wr,
    output logic suspended,
    output logic wake_act,
    output logic clk_en,
    output logic xcvr_en,
    output logic ram_sleep
);

    localparam line_pair_t FS_IDLE = '{dp: 1'b1, dm: 1'b0};
    localparam line_pair_t LS_IDLE = '{dp: 1'b0, dm: 1'b1};

    line_pair_t sync_q [SYNC_STAGES];
    line_pair_t prev_q;
    line_pair_t idle_pair;

    // receive synchronizer chain
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= FS_IDLE;
                else        sync_q[g] <= '{dp: rx_dp, dm: rx_dm};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= FS_IDLE;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= FS_IDLE;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign idle_pair = low_speed ? LS_IDLE : FS_IDLE;
    assign wake_act  = (sync_q[SYNC_STAGES-1] != idle_pair) && (prev_q == idle_pair);

    pwr_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN: begin
                if (set_wr && set_val) state_d = PWR_SUSPEND;
            end
            PWR_SUSPEND: begin
                if (set_wr)                   state_d = set_val ? PWR_SUSPEND : PWR_RUN;
                else if (bare_wr || wake_act) state_d = PWR_RUN;
            end
            default: state_d = PWR_RUN;
        endcase
    end

    // outputs
    always_comb begin
        suspended = 1'b0;
        clk_en    = 1'b1;
        xcvr_en   = 1'b1;
        ram_sleep = 1'b0;
        unique case (state_q)
            PWR_RUN: ;
            PWR_SUSPEND: begin
                suspended = 1'b1;
                clk_en    = 1'b0;
                xcvr_en   = 1'b0;
                ram_sleep = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/usb_line_drive.sv
module usb_line_drive
    import usb_line_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_ce,
    input  logic [1:0]  force_code,
    input  logic        pol_swap,
    input  logic        xcvr_en,
    input  logic        ser_dp,
    input  logic        ser_dm,
    input  logic        ser_oe,
    output logic        usb_dp,
    output logic        usb_dm,
    output logic        usb_oe,
    output link_state_e link_q
);

    link_state_e link_d;
    line_pair_t  pair;
    logic        drive_oe;

    // state register, advanced by the bit clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      link_q <= LINK_PASS;
        else if (bit_ce) link_q <= link_d;
    end

    // next state from the force field
    always_comb begin
        unique case (force_code)
            2'b00:   link_d = LINK_PASS;
            2'b01:   link_d = LINK_SE0;
            2'b10:   link_d = LINK_J;
            2'b11:   link_d = LINK_K;
            default: link_d = LINK_PASS;
        endcase
    end

    // outputs
    always_comb begin
        pair     = '{dp: ser_dp, dm: ser_dm};
        drive_oe = ser_oe;
        unique case (link_q)
            LINK_PASS: ;
            LINK_SE0: begin pair = '{dp: 1'b0, dm: 1'b0}; drive_oe = 1'b1; end
            LINK_J:   begin pair = '{dp: 1'b1, dm: 1'b0}; drive_oe = 1'b1; end
            LINK_K:   begin pair = '{dp: 1'b0, dm: 1'b1}; drive_oe = 1'b1; end
            default: ;
        endcase
        usb_dp = pol_swap ? pair.dm : pair.dp;
        usb_dm = pol_swap ? pair.dp : pair.dm;
        usb_oe = drive_oe && xcvr_en;
    end

endmodule

// File: rtl/usb_line_ctrl.sv
module usb_line_ctrl
    import usb_line_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CTRL_IDX    = 5,
    parameter int POL_IDX     = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic              cpu_a0,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              bit_ce,
    input  logic              ser_dp,
    input  logic              ser_dm,
    input  logic              ser_oe,
    input  logic              rx_dp,
    input  logic              rx_dm,
    output logic              usb_dp,
    output logic              usb_dm,
    output logic              usb_oe,
    output logic              low_speed,
    output logic              sof_en,
    output logic              clk_en,
    output logic              xcvr_en,
    output logic              ram_sleep
);

    localparam logic [DATA_W-1:0] SUSP_MASK = DATA_W'(1) << CTRL_SUSP_BIT;
    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'(1) << CTRL_SPEED_BIT) | (DATA_W'(3) << CTRL_FORCE_LO) | (DATA_W'(1) << CTRL_SOF_BIT);
    localparam logic [DATA_W-1:0] POL_MASK  = DATA_W'(1) << POL_SWAP_BIT;
    localparam logic [DATA_W-1:0] CTRL_SEL  = DATA_W'(CTRL_IDX);
    localparam logic [DATA_W-1:0] POL_SEL   = DATA_W'(POL_IDX);

    logic [DATA_W-1:0] idx_q;
    logic              reg_wr, bare_wr, addr_held;
    logic              ctrl_wr, pol_wr;
    logic [DATA_W-1:0] ctrl_q, pol_q;
    logic              suspended, wake_act;
    link_state_e       link_q;

    usb_cpu_port #(.DATA_W(DATA_W)) i_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_we),
        .cpu_a0    (cpu_a0),
        .cpu_wdata (cpu_wdata),
        .idx_q     (idx_q),
        .reg_wr    (reg_wr),
        .bare_wr   (bare_wr),
        .addr_held (addr_held)
    );

    assign ctrl_wr = reg_wr && (idx_q == CTRL_SEL);
    assign pol_wr  = reg_wr && (idx_q == POL_SEL);

    // configuration storage; suspend lives in the power machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pol_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= cpu_wdata & CTRL_MASK;
            if (pol_wr)  pol_q  <= cpu_wdata & POL_MASK;
        end
    end

    assign low_speed = ctrl_q[CTRL_SPEED_BIT];
    assign sof_en    = ctrl_q[CTRL_SOF_BIT];

    usb_pwr_fsm #(.SYNC_STAGES(SYNC_STAGES)) i_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_dp     (rx_dp),
        .rx_dm     (rx_dm),
        .low_speed (low_speed),
        .set_wr    (ctrl_wr),
        .set_val   (cpu_wdata[CTRL_SUSP_BIT]),
        .bare_wr   (bare_wr),
        .suspended (suspended),
        .wake_act  (wake_act),
        .clk_en    (clk_en),
        .xcvr_en   (xcvr_en),
        .ram_sleep (ram_sleep)
    );

    usb_line_drive i_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_ce     (bit_ce),
        .force_code (ctrl_q[CTRL_FORCE_LO +: 2]),
        .pol_swap   (pol_q[POL_SWAP_BIT]),
        .xcvr_en    (xcvr_en),
        .ser_dp     (ser_dp),
        .ser_dm     (ser_dm),
        .ser_oe     (ser_oe),
        .usb_dp     (usb_dp),
        .usb_dm     (usb_dm),
        .usb_oe     (usb_oe),
        .link_q     (link_q)
    );

    // read-back of the indexed register
    always_comb begin
        cpu_rdata = '0;
        if (idx_q == CTRL_SEL)
            cpu_rdata = ctrl_q | (suspended ? SUSP_MASK : '0);
        else if (idx_q == POL_SEL)
            cpu_rdata = pol_q;
    end

endmodule

// File: rtl/usb_line_ctrl_chk.sv
module usb_line_ctrl_chk
    import usb_line_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_ce,
    input link_state_e       link_q,
    input logic              usb_dp,
    input logic              usb_dm,
    input logic              usb_oe,
    input logic              xcvr_en,
    input logic              clk_en,
    input logic              ram_sleep,
    input logic              wake_act,
    input logic              ctrl_wr,
    input logic              bare_wr,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] pol_q
);

    assert_se0_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q == LINK_SE0 && xcvr_en) |-> (usb_oe && !usb_dp && !usb_dm));

    assert_hold_without_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_ce |=> $stable(link_q));

    assert_j_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q == LINK_J && xcvr_en) |-> (usb_dp == !pol_q[POL_SWAP_BIT] && usb_dm == pol_q[POL_SWAP_BIT]));

    assert_suspend_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sleep |-> (!clk_en && !xcvr_en && !usb_oe));

    assert_activity_wakes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_act && ram_sleep && !ctrl_wr) |=> !ram_sleep);

    assert_bare_keeps_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bare_wr |=> ($stable(ctrl_q) && $stable(pol_q)));

    assert_bare_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bare_wr && ram_sleep) |=> !ram_sleep);

endmodule

bind usb_line_ctrl usb_line_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_ce    (bit_ce),
    .link_q    (link_q),
    .usb_dp    (usb_dp),
    .usb_dm    (usb_dm),
    .usb_oe    (usb_oe),
    .xcvr_en   (xcvr_en),
    .clk_en    (clk_en),
    .ram_sleep (ram_sleep),
    .wake_act  (wake_act),
    .ctrl_wr   (ctrl_wr),
    .bare_wr   (bare_wr),
    .ctrl_q    (ctrl_q),
    .pol_q     (pol_q)
);

// File: tb/test_usb_line_ctrl.sv
`timescale 1ns/1ps
module test_usb_line_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0, cpu_a0 = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       bit_ce = 1'b1;
    logic       ser_dp = 1'b1, ser_dm = 1'b0, ser_oe = 1'b0;
    logic       rx_dp = 1'b1, rx_dm = 1'b0;
    logic       usb_dp, usb_dm, usb_oe, low_speed, sof_en, clk_en, xcvr_en, ram_sleep;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usb_line_ctrl i_usb_line_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_a0(cpu_a0),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bit_ce(bit_ce),
        .ser_dp(ser_dp), .ser_dm(ser_dm), .ser_oe(ser_oe),
        .rx_dp(rx_dp), .rx_dm(rx_dm), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .usb_oe(usb_oe), .low_speed(low_speed), .sof_en(sof_en),
        .clk_en(clk_en), .xcvr_en(xcvr_en), .ram_sleep(ram_sleep)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit we, input bit a0, input logic [7:0] d);
        @(negedge clk);
        cpu_we = we; cpu_a0 = a0; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        cyc(1'b1, 1'b0, idx);
        cyc(1'b1, 1'b1, d);
    endtask

    task automatic rd(input logic [7:0] idx);
        cyc(1'b1, 1'b0, idx);
    endtask

    function automatic int line3(input bit dp, input bit dm, input bit oe);
        return {29'd0, dp, dm, oe};
    endfunction

    function automatic int expect_line(input int pol, input int frc, input int ser);
        bit dp, dm, oe;
        dp = ser[2]; dm = ser[1]; oe = ser[0];
        if (frc == 1) begin dp = 0; dm = 0; oe = 1; end
        if (frc == 2) begin dp = 1; dm = 0; oe = 1; end
        if (frc == 3) begin dp = 0; dm = 1; oe = 1; end
        if (pol != 0) return line3(dm, dp, oe);
        return line3(dp, dm, oe);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'd5);  chk("R1 ctrl", cpu_rdata, 8'h00);
        rd(8'd15); chk("R1 pol", cpu_rdata, 8'h00);
        chk("R1 enables", {clk_en, xcvr_en, ram_sleep, low_speed, sof_en}, 5'b11000);
        ser_dp = 0; ser_dm = 1; ser_oe = 1; #1;
        chk("R1 pass", line3(usb_dp, usb_dm, usb_oe), line3(0, 1, 1));

        // R3 R5 sweep over polarity, force code, serializer pattern
        for (int pol = 0; pol < 2; pol++) begin
            wr(8'd15, 8'(pol << 6));
            for (int frc = 0; frc < 4; frc++) begin
                wr(8'd5, 8'(frc << 3));
                @(negedge clk);
                for (int s = 0; s < 8; s++) begin
                    ser_dp = s[2]; ser_dm = s[1]; ser_oe = s[0]; #1;
                    chk(pol != 0 ? "R5 swapped line" : "R3 line",
                        line3(usb_dp, usb_dm, usb_oe), expect_line(pol, frc, s));
                end
            end
        end
        wr(8'd15, 8'h00);
        wr(8'd5, 8'h00);
        @(negedge clk);

        // R2 readback masking, unknown index ignored
        wr(8'd15, 8'hFF); rd(8'd15); chk("R2 pol mask", cpu_rdata, 8'h40);
        wr(8'd15, 8'h00);
        wr(8'd3, 8'hFF);  rd(8'd3);  chk("R2 other idx", cpu_rdata, 8'h00);
        rd(8'd5); chk("R2 ctrl untouched", cpu_rdata, 8'h00);
        cyc(1'b1, 1'b1, 8'h00);

        // R9 speed and SOF
        wr(8'd5, 8'h21);
        chk("R9 outputs", {low_speed, sof_en}, 2'b11);
        rd(8'd5); chk("R9 readback", cpu_rdata, 8'h21);
        cyc(1'b1, 1'b1, 8'h00);

        // R4 force waits for bit_ce
        ser_dp = 1; ser_dm = 0; ser_oe = 1;
        bit_ce = 1'b0;
        wr(8'd5, 8'h18);
        repeat (3) @(negedge clk);
        #1 chk("R4 held", line3(usb_dp, usb_dm, usb_oe), line3(1, 0, 1));
        bit_ce = 1'b1;
        @(negedge clk);
        #1 chk("R4 applied", line3(usb_dp, usb_dm, usb_oe), line3(0, 1, 1));

        // R10 reset sequence
        ser_oe = 0;
        wr(8'd5, 8'h08); @(negedge clk);
        #1 chk("R10 se0", line3(usb_dp, usb_dm, usb_oe), line3(0, 0, 1));
        wr(8'd5, 8'h00); @(negedge clk);
        #1 chk("R10 normal", line3(usb_dp, usb_dm, usb_oe), line3(1, 0, 0));

        // R6 suspend, R7 wake by full-speed activity
        ser_oe = 1;
        wr(8'd5, 8'h40);
        #1 chk("R6 gated", {clk_en, xcvr_en, ram_sleep, usb_oe}, 4'b0010);
        repeat (4) @(negedge clk);
        chk("R7 idle keeps sleep", ram_sleep, 1);
        rx_dp = 0; rx_dm = 1;
        @(negedge clk); @(negedge clk);
        chk("R7 not yet", ram_sleep, 1);
        @(negedge clk);
        chk("R7 woke", ram_sleep, 0);
        rd(8'd5); chk("R7 bit cleared", cpu_rdata, 8'h00);
        cyc(1'b1, 1'b1, 8'h00);

        // R7 low-speed idle
        repeat (4) @(negedge clk);
        wr(8'd5, 8'h60);
        chk("R7 ls sleep", {ram_sleep, low_speed}, 2'b11);
        repeat (3) @(negedge clk);
        chk("R7 ls idle keeps", ram_sleep, 1);
        rx_dp = 1; rx_dm = 0;
        @(negedge clk); @(negedge clk);
        chk("R7 ls not yet", ram_sleep, 1);
        @(negedge clk);
        chk("R7 ls woke", ram_sleep, 0);
        rd(8'd5); chk("R7 ls regs", cpu_rdata, 8'h20);
        cyc(1'b1, 1'b1, 8'h00);
        repeat (4) @(negedge clk);

        // R8 bare write wakes without writing
        wr(8'd5, 8'hFF);
        chk("R8 suspended", ram_sleep, 1);
        rd(8'd5); chk("R2 ctrl mask", cpu_rdata, 8'h79);
        cyc(1'b1, 1'b1, 8'hFF);
        chk("R8 addressed keeps", ram_sleep, 1);
        cyc(1'b1, 1'b1, 8'h00);
        chk("R8 bare wake", ram_sleep, 0);
        rd(8'd5); chk("R8 regs kept", cpu_rdata, 8'h39);
        cyc(1'b1, 1'b1, 8'h00);
        cyc(1'b1, 1'b1, 8'hFF);
        chk("R8 bare awake", ram_sleep, 0);
        rd(8'd5); chk("R8 no write", cpu_rdata, 8'h00);
        rd(8'd15); chk("R8 pol kept", cpu_rdata, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule